// File: doc/BRIEF.md
# Inbound Doorbell Capture Queue

This block receives inbound doorbell events, each carrying an 8-bit source identifier, an 8-bit target identifier and a 16-bit info word. It turns every accepted event into one 8-byte record and writes that record to a circular queue in memory. The queue holds 512 records. The block keeps two pointers: an enqueue pointer that it advances in hardware, and a dequeue pointer that software advances. It raises an interrupt while records are pending or while an error or overflow flag is set.

Software sets up the queue by loading both pointers with the ring base address and then writing the mode word with the enable bit set. For each interrupt, software reads the record at the dequeue pointer. It then writes the mode word with the advance bit set, which moves the dequeue pointer forward by one record. Finally it writes 1 to the queued flag to clear it. The ring offset is the low 12 address bits of a pointer, and those bits wrap. The upper bits hold the base address and are never changed by an increment.

Top module: `dbq_capture`

## Requirements
- R1: After synchronous reset, the mode, status, dequeue-pointer and enqueue-pointer registers all read zero, `irq` is low and `mem_we` is low.
- R2: A stored record is 64 bits, with byte 0 in bits 63:56. The target ID is in byte 3 (bits 39:32). The source ID is in byte 5 (bits 23:16). The info word is in bytes 6 and 7 (bits 15:0), most significant byte first.
- R3: A doorbell accepted in one cycle produces `mem_we` high on the next edge, with `mem_addr` equal to the enqueue pointer. The enqueue pointer then advances by 8.
- R4: Bytes 0, 1, 2 and 4 of every written record are zero.
- R5: A doorbell that arrives while 511 records are pending is dropped: nothing is written and the enqueue pointer does not move. It sets status bit 4 (full).
- R6: A doorbell that arrives while mode bit 0 (enable) is clear is dropped and sets status bit 7 (error).
- R7: A pointer increment wraps within address bits 11:3 and leaves bits 31:12 unchanged, so 0x10000FF8 advances to 0x10000000. Loads into a pointer force bits 2:0 to zero.
- R8: Register map: 0 holds the mode word, 1 holds status, 2 holds the dequeue pointer and 3 holds the enqueue pointer. Writing the mode word with bit 1 set advances the dequeue pointer by one record. Bit 1 is not stored and always reads 0; the other mode bits read back as written.
- R9: Status bits 7, 4 and 0 clear when 1 is written to them. Writing 0 to a bit leaves it unchanged, and writing 0x91 clears all three in one write.
- R10: Status bit 0 (queued) is set whenever the two pointers differ. Clearing it while records are still pending has no lasting effect: the bit reads 1 again.
- R11: `irq` is high exactly while any of status bits 7, 4 or 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| db_valid | input | 1 | Inbound doorbell present this cycle |
| db_src | input | 8 | Doorbell source ID |
| db_tgt | input | 8 | Doorbell target ID |
| db_info | input | 16 | Doorbell info word |
| mem_we | output | 1 | Record write strobe |
| mem_addr | output | 32 | Byte address of the record |
| mem_data | output | 64 | Record contents |
| irq | output | 1 | Interrupt request |

## Verification
The bench places the pointers one record short of a full ring. A design that miscounted occupancy there would either overwrite the record at the dequeue pointer or refuse a doorbell that still had room. It starts a ring at offset 0xFF8 to catch a carry out of bit 11 corrupting the base address. It also clears the queued flag while records remain pending. A design that kept that bit as a plain sticky flag would then silence the interrupt and strand the queue. Finally, it checks that writing 0 to a status bit and writing the advance bit of the mode word leave the state they should not touch unchanged.

// File: rtl/dbq_pkg.sv
package dbq_pkg;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DEQ  = 2'd2,
        SEL_ENQ  = 2'd3
    } reg_sel_e;

    localparam int MODE_EN_BIT  = 0;
    localparam int MODE_ADV_BIT = 1;
    localparam int ST_ERR_BIT   = 7;
    localparam int ST_FULL_BIT  = 4;
    localparam int ST_Q_BIT     = 0;

    // Fixed 8-byte record; byte 0 is the most significant
    typedef struct packed {
        logic [23:0] zero_hi;   // bytes 0..2
        logic [7:0]  tgt;       // byte 3
        logic [7:0]  zero_mid;  // byte 4
        logic [7:0]  src;       // byte 5
        logic [15:0] info;      // bytes 6..7
    } dbq_rec_t;

    function automatic dbq_rec_t build_rec(input logic [7:0] src,
                                           input logic [7:0] tgt,
                                           input logic [15:0] info);
        dbq_rec_t r;
        r.zero_hi  = '0;
        r.tgt      = tgt;
        r.zero_mid = '0;
        r.src      = src;
        r.info     = info;
        return r;
    endfunction

endpackage

// File: rtl/dbq_ptr.sv
module dbq_ptr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_nxt
);
    localparam int SLOT_W = OFF_W - 3;

    logic [SLOT_W-1:0] slot_inc;

    assign slot_inc = ptr[OFF_W-1:3] + 1'b1;

    always_comb begin
        ptr_nxt = ptr;
        if (load)
            ptr_nxt = {load_val[ADDR_W-1:3], 3'b000};
        else if (step)
            ptr_nxt = {ptr[ADDR_W-1:OFF_W], slot_inc, 3'b000};
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else     ptr <= ptr_nxt;
    end
endmodule

// File: rtl/dbq_status.sv
module dbq_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_err,
    input  logic       set_full,
    input  logic       pending_nxt,
    input  logic       clr_wr,
    input  logic [7:0] clr_mask,
    output logic [7:0] stat
);
    import dbq_pkg::*;

    logic err_q, full_q, q_q;
    logic [7:0] clr;

    assign clr = clr_wr ? clr_mask : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= 1'b0;
            full_q <= 1'b0;
            q_q    <= 1'b0;
        end else begin
            err_q  <= set_err  | (err_q  & ~clr[ST_ERR_BIT]);
            full_q <= set_full | (full_q & ~clr[ST_FULL_BIT]);
            q_q    <= pending_nxt | (q_q & ~clr[ST_Q_BIT]);
        end
    end

    always_comb begin
        stat              = 8'h00;
        stat[ST_ERR_BIT]  = err_q;
        stat[ST_FULL_BIT] = full_q;
        stat[ST_Q_BIT]    = q_q;
    end
endmodule

// File: rtl/dbq_capture.sv
module dbq_capture #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int DEPTH_LOG2 = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              db_valid,
    input  logic [7:0]        db_src,
    input  logic [7:0]        db_tgt,
    input  logic [15:0]       db_info,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_data,
    output logic              irq
);
    import dbq_pkg::*;

    localparam int OFF_W = DEPTH_LOG2 + 3;

    reg_sel_e          sel;
    logic [DATA_W-1:0] mode_q;
    logic              enable;
    logic              wr_mode, wr_stat, wr_deq, wr_enq, advance;
    logic [ADDR_W-1:0] deq_ptr, deq_nxt, enq_ptr, enq_nxt;
    logic [DEPTH_LOG2-1:0] used;
    logic              full_cond, accept;
    logic [7:0]        stat;

    assign sel     = reg_sel_e'(reg_addr);
    assign enable  = mode_q[MODE_EN_BIT];
    assign wr_mode = reg_wr && (sel == SEL_MODE);
    assign wr_stat = reg_wr && (sel == SEL_STAT);
    assign wr_deq  = reg_wr && (sel == SEL_DEQ);
    assign wr_enq  = reg_wr && (sel == SEL_ENQ);
    assign advance = wr_mode && reg_wdata[MODE_ADV_BIT];

    assign used      = enq_ptr[OFF_W-1:3] - deq_ptr[OFF_W-1:3];
    assign full_cond = (used == {DEPTH_LOG2{1'b1}});
    assign accept    = db_valid && enable && !full_cond;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= reg_wdata;
            mode_q[MODE_ADV_BIT] <= 1'b0;
        end
    end

    dbq_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_deq (
        .clk(clk), .rst(rst), .load(wr_deq),
        .load_val(reg_wdata[ADDR_W-1:0]), .step(advance),
        .ptr(deq_ptr), .ptr_nxt(deq_nxt)
    );

    dbq_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_enq (
        .clk(clk), .rst(rst), .load(wr_enq),
        .load_val(reg_wdata[ADDR_W-1:0]), .step(accept),
        .ptr(enq_ptr), .ptr_nxt(enq_nxt)
    );

    dbq_status u_stat (
        .clk(clk), .rst(rst),
        .set_err(db_valid && !enable),
        .set_full(db_valid && enable && full_cond),
        .pending_nxt(enq_nxt != deq_nxt),
        .clr_wr(wr_stat), .clr_mask(reg_wdata[7:0]),
        .stat(stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            mem_we <= accept;
            if (accept) begin
                mem_addr <= enq_ptr;
                mem_data <= build_rec(db_src, db_tgt, db_info);
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_MODE: reg_rdata = mode_q;
            SEL_STAT: reg_rdata = DATA_W'(stat);
            SEL_DEQ:  reg_rdata = DATA_W'(deq_ptr);
            default:  reg_rdata = DATA_W'(enq_ptr);
        endcase
    end

    assign irq = |stat;
endmodule

// File: rtl/dbq_capture_chk.sv
module dbq_capture_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              db_valid,
    input logic              reg_wr,
    input logic              enable,
    input logic              full_cond,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_data,
    input logic [ADDR_W-1:0] enq_ptr,
    input logic [ADDR_W-1:0] deq_ptr,
    input logic [7:0]        stat,
    input logic              irq
);
    // R3: an accepted doorbell is written on the next edge
    a_r3_capture_next: assert property (@(posedge clk) disable iff (rst)
        (db_valid && enable && !full_cond) |=> mem_we);

    // R5: a doorbell into a full ring is dropped and flagged
    a_r5_full_drop: assert property (@(posedge clk) disable iff (rst)
        (db_valid && enable && full_cond) |=> (!mem_we && stat[4]));

    // R6: a doorbell while disabled is dropped and flagged
    a_r6_disabled_drop: assert property (@(posedge clk) disable iff (rst)
        (db_valid && !enable) |=> (!mem_we && stat[7]));

    // R4: padding bytes are zero
    a_r4_zero_pad: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_data[63:40] == 24'h0 && mem_data[31:24] == 8'h0));

    // R7: records land on 8-byte boundaries
    a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[2:0] == 3'b000));

    // R10: differing pointers always show the queued flag
    a_r10_queued_tracks: assert property (@(posedge clk) disable iff (rst)
        (enq_ptr != deq_ptr) |-> stat[0]);

    // R11: interrupt only rises after a doorbell or a register write
    a_r11_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(db_valid) || $past(reg_wr)));
endmodule

bind dbq_capture dbq_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .db_valid(db_valid), .reg_wr(reg_wr),
    .enable(enable), .full_cond(full_cond), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data), .enq_ptr(enq_ptr),
    .deq_ptr(deq_ptr), .stat(stat), .irq(irq)
);

// File: tb/dbq_capture_bench.sv
module dbq_capture_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        db_valid = 1'b0;
    logic [7:0]  db_src = '0;
    logic [7:0]  db_tgt = '0;
    logic [15:0] db_info = '0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic        got_we;
    logic [31:0] got_addr;
    logic [63:0] got_data;

    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam logic [31:0] CFG  = 32'h0010_8161;

    always #5 clk = ~clk;

    dbq_capture u_dbq_capture (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
        .db_src(db_src), .db_tgt(db_tgt), .db_info(db_info),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ring_bell(input logic [7:0] s, input logic [7:0] t, input logic [15:0] i);
        @(negedge clk);
        db_valid = 1'b1; db_src = s; db_tgt = t; db_info = i;
        @(posedge clk);
        #1;
        got_we = mem_we; got_addr = mem_addr; got_data = mem_data;
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    function automatic logic [63:0] rec(input logic [7:0] s, input logic [7:0] t, input logic [15:0] i);
        return {24'h0, t, 8'h0, s, i};
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            rd_reg(k[1:0], v);
            check("R1 register zero", v, 0);
        end
        check("R1 irq low", irq, 0);
        check("R1 no write", mem_we, 0);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        ring_bell(8'h11, 8'h22, 16'h3344);
        check("R6 no write while disabled", got_we, 0);
        rd_reg(2'd1, v);
        check("R6 error flag", v, 32'h80);
        check("R11 irq on error", irq, 1);
        rd_reg(2'd3, v);
        check("R6 enqueue unmoved", v, 0);
        wr_reg(2'd1, 32'h7F);
        rd_reg(2'd1, v);
        check("R9 zero bit leaves flag", v, 32'h80);
        wr_reg(2'd1, 32'h80);
        rd_reg(2'd1, v);
        check("R9 error cleared", v, 0);
        check("R11 irq low", irq, 0);
    endtask

    task automatic t_config;
        logic [31:0] v;
        wr_reg(2'd2, BASE | 32'h5);
        wr_reg(2'd3, BASE);
        wr_reg(2'd0, CFG);
        rd_reg(2'd0, v);
        check("R8 mode readback", v, CFG);
        rd_reg(2'd2, v);
        check("R7 load drops low bits", v, BASE);
    endtask

    task automatic t_single;
        logic [31:0] v;
        ring_bell(8'hA5, 8'h3C, 16'hBEEF);
        check("R3 write strobe", got_we, 1);
        check("R3 write address", got_addr, BASE);
        check("R2 R4 record layout", got_data, rec(8'hA5, 8'h3C, 16'hBEEF));
        rd_reg(2'd3, v);
        check("R3 enqueue advanced", v, BASE + 8);
        rd_reg(2'd1, v);
        check("R10 queued set", v, 32'h01);
        check("R11 irq pending", irq, 1);
        wr_reg(2'd0, CFG | 32'h2);
        rd_reg(2'd0, v);
        check("R8 advance bit self-clears", v, CFG);
        rd_reg(2'd2, v);
        check("R8 dequeue advanced", v, BASE + 8);
        wr_reg(2'd1, 32'h01);
        rd_reg(2'd1, v);
        check("R9 queued cleared when empty", v, 0);
        check("R11 irq idle", irq, 0);
    endtask

    task automatic t_reassert;
        logic [31:0] v;
        ring_bell(8'h01, 8'h02, 16'h0304);
        check("R2 second record", got_data, rec(8'h01, 8'h02, 16'h0304));
        ring_bell(8'hFF, 8'hEE, 16'hDDCC);
        check("R3 third address", got_addr, BASE + 16);
        wr_reg(2'd1, 32'h01);
        rd_reg(2'd1, v);
        check("R10 queued reasserts", v, 32'h01);
        check("R11 irq stays", irq, 1);
        wr_reg(2'd0, CFG | 32'h2);
        wr_reg(2'd0, CFG | 32'h2);
        wr_reg(2'd1, 32'h01);
        rd_reg(2'd1, v);
        check("R10 queue drained", v, 0);
    endtask

    task automatic t_full;
        logic [31:0] v;
        wr_reg(2'd2, BASE);
        wr_reg(2'd3, BASE + 32'hFF8);
        ring_bell(8'h55, 8'h66, 16'h7788);
        check("R5 dropped when full", got_we, 0);
        rd_reg(2'd3, v);
        check("R5 enqueue held", v, BASE + 32'hFF8);
        rd_reg(2'd1, v);
        check("R5 full flag", v, 32'h11);
        wr_reg(2'd1, 32'h91);
        rd_reg(2'd1, v);
        check("R9 R10 group clear leaves queued", v, 32'h01);
        wr_reg(2'd2, BASE + 32'hFF8);
        wr_reg(2'd1, 32'h01);
        rd_reg(2'd1, v);
        check("R9 all clear", v, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        ring_bell(8'h9A, 8'hBC, 16'h0102);
        check("R7 write at ring top", got_addr, BASE + 32'hFF8);
        check("R2 wrap record", got_data, rec(8'h9A, 8'hBC, 16'h0102));
        rd_reg(2'd3, v);
        check("R7 enqueue wraps keeping base", v, BASE);
        wr_reg(2'd0, CFG | 32'h2);
        rd_reg(2'd2, v);
        check("R7 dequeue wraps keeping base", v, BASE);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_disabled();
        t_config();
        t_single();
        t_reassert();
        t_full();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule